// File: doc/BRIEF.md
# Configuration Readback Sequencer

This block reads back the complete configuration image of a programmable device through a byte-wide internal configuration port. A start pulse makes it write a fixed command packet, 44 bytes long, into the port. The packet aligns the port, writes the device identity, selects read-configuration mode, sets the starting frame address and asks for a fixed number of 32-bit words. The block then turns the port around to read mode. It collects the returned bytes and throws away everything that is not frame payload.

The data that comes back is a run of equal slots. Each slot is a few padding bytes followed by one frame of payload, and the leading slot or slots are padding from end to end. Only payload bytes go out on a valid/ready stream, each one tagged with its frame index and its byte offset inside the frame. A one-cycle pulse marks the transfer of the final byte. If the device stops answering for a programmable number of cycles, the block gives up, drops the port select and holds a sticky stall flag next to the number of payload bytes it received.

Top module: `cfgrb_seq`

## Requirements
- R1: While and after a synchronous reset, cfg_cs, cfg_we, cfg_rd_en, out_vld, done and stall are 0, cfg_dout is 0x00 and rx_count is 0.
- R2: From the cycle after a start pulse seen while idle, the block holds cfg_cs=1 and cfg_we=1 for 44 cycles. During those cycles cfg_dout carries these words, most significant byte first: FFFFFFFF, AA995566, 3001C001, DEV_ID (default 0124A093), 30008001, 00000004, 30002001, FRAME_ADDR (default 00000000), 28006000, 0x48000000 OR'd with RD_WORDS (default 480222FA), 00000000. Outside that window cfg_we is 0 and cfg_dout is 0x00.
- R3: After the last command byte, cfg_cs stays 1 and cfg_we drops to 0. cfg_rd_en is 1 while reading, unless the whole stream has been received or an output byte is waiting with out_rdy low. A byte is taken in a cycle where cfg_rd_en and cfg_din_vld are both 1.
- R4: The read stream holds LEAD_FRAMES+NUM_FRAMES slots of PAD_BYTES+FRAME_BYTES bytes each. The first LEAD_FRAMES slots, and the first PAD_BYTES bytes of every slot, are discarded. A kept byte at offset p of slot s carries out_frame = s-LEAD_FRAMES and out_byte = p-PAD_BYTES.
- R5: A kept byte appears on out_data with out_vld=1 in the cycle after it is taken. It stays stable until the cycle in which out_rdy is 1.
- R6: done is 1 for exactly one cycle, the cycle after the transfer of byte FRAME_BYTES-1 of frame NUM_FRAMES-1. In that same cycle cfg_cs is 0 and the block is idle.
- R7: Suppose cfg_rd_en is 1 and cfg_din_vld is 0 for tmo_limit cycles, counting only such waiting cycles since the last byte was taken. Then stall becomes 1 and cfg_cs drops to 0 in the next cycle. stall stays 1 until the next accepted start, and rx_count keeps the payload count.
- R8: A start pulse that arrives while the block is not idle is ignored. The running command sequence or readback goes on unchanged, and the run produces one done pulse.
- R9: rx_count counts the payload bytes taken since the last accepted start. It equals NUM_FRAMES*FRAME_BYTES when done fires.
- R10: A reset in the middle of a run returns the block to idle with cfg_cs=0 and stall=0. A following start performs a complete readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a readback (used only while idle) |
| tmo_limit | input | TMO_W | Waiting cycles tolerated before stall |
| cfg_cs | output | 1 | Configuration port select |
| cfg_we | output | 1 | Port write enable (command phase) |
| cfg_dout | output | 8 | Command byte to the port |
| cfg_rd_en | output | 1 | Read request to the port |
| cfg_din | input | 8 | Byte returned by the port |
| cfg_din_vld | input | 1 | cfg_din holds a byte |
| out_vld | output | 1 | Payload byte valid |
| out_rdy | input | 1 | Downstream accepts payload byte |
| out_data | output | 8 | Payload byte |
| out_frame | output | FRM_W | Frame index of payload byte |
| out_byte | output | BYT_W | Offset of payload byte in its frame |
| done | output | 1 | One-cycle pulse after last payload byte |
| stall | output | 1 | Sticky timeout flag |
| rx_count | output | CNT_W | Payload bytes taken in this run |

## Verification
The properties assume three things about the inputs. tmo_limit is at least 1 and does not change during a run. cfg_din_vld means something only in a cycle where cfg_rd_en is 1. The downstream may hold out_rdy low for any length of time. The stimulus keeps tmo_limit at one value for the whole test and gaps the returned bytes at most one cycle at a time, except in the test that forces a stall. It drives start pulses in both the command phase and the read phase to show that they are ignored. Backpressure from a fixed pattern on out_rdy exercises the holding of the output and the gating of read requests.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_READ = 2'd2
   } rb_state_e;

   localparam int unsigned CMD_WORDS = 11;
   localparam int unsigned CMD_BYTES = CMD_WORDS * 4;

   // command packet word by position; order is behaviour
   function automatic logic [31:0] cmd_word(input logic [3:0]  idx,
                                            input logic [31:0] dev_id,
                                            input logic [31:0] frame_addr,
                                            input logic [26:0] rd_words);
      logic [31:0] w;
      case (idx)
         4'd0:    w = 32'hFFFF_FFFF;
         4'd1:    w = 32'hAA99_5566;
         4'd2:    w = 32'h3001_C001;
         4'd3:    w = dev_id;
         4'd4:    w = 32'h3000_8001;
         4'd5:    w = 32'h0000_0004;
         4'd6:    w = 32'h3000_2001;
         4'd7:    w = frame_addr;
         4'd8:    w = 32'h2800_6000;
         4'd9:    w = {5'b01001, rd_words};
         default: w = 32'h0000_0000;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/cfgrb_cmd_emitter.sv
module cfgrb_cmd_emitter
   import cfgrb_pkg::*;
#(
   parameter logic [31:0] DEV_ID     = 32'h0124_A093,
   parameter logic [31:0] FRAME_ADDR = 32'h0000_0000,
   parameter int unsigned RD_WORDS   = 32'h0002_22FA
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       run,
   output logic [7:0] byte_o,
   output logic       last_o
);
   localparam int unsigned POS_W = $clog2(CMD_BYTES);

   logic [POS_W-1:0] pos;
   logic [31:0]      word;
   logic [7:0]       sel;

   always_ff @(posedge clk) begin
      if (rst || !run) pos <= '0;
      else             pos <= pos + 1'b1;
   end

   always_comb begin
      word = cmd_word(pos[POS_W-1:2], DEV_ID, FRAME_ADDR, 27'(RD_WORDS));
      case (pos[1:0])
         2'd0:    sel = word[31:24];
         2'd1:    sel = word[23:16];
         2'd2:    sel = word[15:8];
         default: sel = word[7:0];
      endcase
   end

   assign byte_o = run ? sel : 8'h00;
   assign last_o = run && (pos == POS_W'(CMD_BYTES - 1));

   a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
      run |-> pos < POS_W'(CMD_BYTES))
      else $error("a_r2_pos_in_range");

endmodule

// File: rtl/cfgrb_frame_stripper.sv
module cfgrb_frame_stripper #(
   parameter int unsigned FRAME_BYTES = 424,
   parameter int unsigned NUM_FRAMES  = 1320,
   parameter int unsigned PAD_BYTES   = 4,
   parameter int unsigned LEAD_FRAMES = 1,
   localparam int unsigned FRM_W = $clog2(NUM_FRAMES + 1),
   localparam int unsigned BYT_W = $clog2(FRAME_BYTES + 1),
   localparam int unsigned CNT_W = $clog2(NUM_FRAMES * FRAME_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             accept,
   input  logic [7:0]       din,
   input  logic             out_rdy,
   output logic             out_vld,
   output logic [7:0]       out_data,
   output logic [FRM_W-1:0] out_frame,
   output logic [BYT_W-1:0] out_byte,
   output logic             all_rx,
   output logic             final_xfer,
   output logic [CNT_W-1:0] rx_count
);
   localparam int unsigned SLOT_BYTES = PAD_BYTES + FRAME_BYTES;
   localparam int unsigned SLOTS      = NUM_FRAMES + LEAD_FRAMES;
   localparam int unsigned POS_W      = $clog2(SLOT_BYTES);
   localparam int unsigned SLOT_W     = $clog2(SLOTS + 1);

   logic [POS_W-1:0]  pos;
   logic [SLOT_W-1:0] slot;
   logic              in_pad, in_lead, slot_end, stream_end, keep, out_last;

   generate
      if (PAD_BYTES == 0) begin : g_nopad
         assign in_pad = 1'b0;
      end else begin : g_pad
         assign in_pad = pos < POS_W'(PAD_BYTES);
      end
      if (LEAD_FRAMES == 0) begin : g_nolead
         assign in_lead = 1'b0;
      end else begin : g_lead
         assign in_lead = slot < SLOT_W'(LEAD_FRAMES);
      end
   endgenerate

   assign slot_end   = pos == POS_W'(SLOT_BYTES - 1);
   assign stream_end = slot_end && (slot == SLOT_W'(SLOTS - 1));
   assign keep       = !in_pad && !in_lead;
   assign final_xfer = out_vld && out_rdy && out_last;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         pos       <= '0;
         slot      <= '0;
         all_rx    <= 1'b0;
         out_vld   <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= 8'h00;
         out_frame <= '0;
         out_byte  <= '0;
         rx_count  <= '0;
      end else begin
         if (out_vld && out_rdy) out_vld <= 1'b0;
         if (accept) begin
            pos <= slot_end ? '0 : pos + 1'b1;
            if (slot_end)   slot   <= slot + 1'b1;
            if (stream_end) all_rx <= 1'b1;
            if (keep) begin
               out_vld   <= 1'b1;
               out_data  <= din;
               out_frame <= FRM_W'(slot - SLOT_W'(LEAD_FRAMES));
               out_byte  <= BYT_W'(pos - POS_W'(PAD_BYTES));
               out_last  <= stream_end;
               rx_count  <= rx_count + 1'b1;
            end
         end
      end
   end

   a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst || clear)
      (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_frame) && $stable(out_byte)))
      else $error("a_r5_hold_stable");

   a_r4_byte_range: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_byte < BYT_W'(FRAME_BYTES)))
      else $error("a_r4_byte_range");

   a_r4_frame_range: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_frame < FRM_W'(NUM_FRAMES)))
      else $error("a_r4_frame_range");

   a_r3_no_accept_when_full: assert property (@(posedge clk) disable iff (rst)
      all_rx |-> !accept)
      else $error("a_r3_no_accept_when_full");

endmodule

// File: rtl/cfgrb_stall_timer.sv
module cfgrb_stall_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             waiting,
   input  logic             got,
   input  logic [TMO_W-1:0] limit,
   output logic             hit,
   output logic             stall
);
   logic [TMO_W-1:0] cnt;

   assign hit = waiting && (cnt == limit - 1'b1);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt   <= '0;
         stall <= 1'b0;
      end else if (hit) begin
         cnt   <= '0;
         stall <= 1'b1;
      end else if (got) begin
         cnt <= '0;
      end else if (waiting) begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (stall && !clear) |=> stall)
      else $error("a_r7_sticky");

endmodule

// File: rtl/cfgrb_seq.sv
module cfgrb_seq
   import cfgrb_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 424,
   parameter int unsigned NUM_FRAMES  = 1320,
   parameter int unsigned PAD_BYTES   = 4,
   parameter int unsigned LEAD_FRAMES = 1,
   parameter int unsigned TMO_W       = 16,
   parameter logic [31:0] DEV_ID      = 32'h0124_A093,
   parameter logic [31:0] FRAME_ADDR  = 32'h0000_0000,
   parameter int unsigned RD_WORDS    = 32'h0002_22FA,
   localparam int unsigned FRM_W = $clog2(NUM_FRAMES + 1),
   localparam int unsigned BYT_W = $clog2(FRAME_BYTES + 1),
   localparam int unsigned CNT_W = $clog2(NUM_FRAMES * FRAME_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [TMO_W-1:0] tmo_limit,
   output logic             cfg_cs,
   output logic             cfg_we,
   output logic [7:0]       cfg_dout,
   output logic             cfg_rd_en,
   input  logic [7:0]       cfg_din,
   input  logic             cfg_din_vld,
   output logic             out_vld,
   input  logic             out_rdy,
   output logic [7:0]       out_data,
   output logic [FRM_W-1:0] out_frame,
   output logic [BYT_W-1:0] out_byte,
   output logic             done,
   output logic             stall,
   output logic [CNT_W-1:0] rx_count
);
   rb_state_e state;
   logic      go, cmd_last, all_rx, final_xfer, stall_hit, accept, waiting;

   assign go        = start && (state == ST_IDLE);
   assign cfg_cs    = state != ST_IDLE;
   assign cfg_we    = state == ST_CMD;
   assign cfg_rd_en = (state == ST_READ) && !all_rx && !(out_vld && !out_rdy);
   assign accept    = cfg_rd_en && cfg_din_vld;
   assign waiting   = cfg_rd_en && !cfg_din_vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         done <= final_xfer;
         case (state)
            ST_IDLE: if (go) state <= ST_CMD;
            ST_CMD:  if (cmd_last) state <= ST_READ;
            ST_READ: if (stall_hit || final_xfer) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   cfgrb_cmd_emitter #(
      .DEV_ID(DEV_ID), .FRAME_ADDR(FRAME_ADDR), .RD_WORDS(RD_WORDS)
   ) u_emit (
      .clk(clk), .rst(rst), .run(state == ST_CMD),
      .byte_o(cfg_dout), .last_o(cmd_last)
   );

   cfgrb_frame_stripper #(
      .FRAME_BYTES(FRAME_BYTES), .NUM_FRAMES(NUM_FRAMES),
      .PAD_BYTES(PAD_BYTES), .LEAD_FRAMES(LEAD_FRAMES)
   ) u_strip (
      .clk(clk), .rst(rst), .clear(go), .accept(accept), .din(cfg_din),
      .out_rdy(out_rdy), .out_vld(out_vld), .out_data(out_data),
      .out_frame(out_frame), .out_byte(out_byte), .all_rx(all_rx),
      .final_xfer(final_xfer), .rx_count(rx_count)
   );

   cfgrb_stall_timer #(.TMO_W(TMO_W)) u_tmo (
      .clk(clk), .rst(rst), .clear(go), .waiting(waiting), .got(accept),
      .limit(tmo_limit), .hit(stall_hit), .stall(stall)
   );

   a_r2_first_dummy: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_we) |-> (cfg_dout == 8'hFF))
      else $error("a_r2_first_dummy");

   a_r3_read_not_write: assert property (@(posedge clk) disable iff (rst)
      cfg_rd_en |-> (cfg_cs && !cfg_we))
      else $error("a_r3_read_not_write");

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done)
      else $error("a_r6_done_single");

   a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
      done |-> !cfg_cs)
      else $error("a_r6_done_idle");

   a_r7_stall_deselect: assert property (@(posedge clk) disable iff (rst)
      stall |-> !cfg_cs)
      else $error("a_r7_stall_deselect");

   a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
      (state == ST_READ && start) |=> (state != ST_CMD))
      else $error("a_r8_no_restart");

   a_r9_count_at_done: assert property (@(posedge clk) disable iff (rst)
      done |-> (rx_count == CNT_W'(NUM_FRAMES * FRAME_BYTES)))
      else $error("a_r9_count_at_done");

endmodule

// File: tb/cfgrb_seq_bench.sv
module cfgrb_seq_bench;
   localparam int FB = 8, NF = 3, PB = 4, LF = 1, TW = 8;
   localparam int SLOT = PB + FB, TOTAL = (NF + LF) * SLOT;
   localparam int FRM_W = $clog2(NF + 1), BYT_W = $clog2(FB + 1), CNT_W = $clog2(NF * FB + 1);
   localparam logic [31:0] DEVID = 32'h0124_A093;
   localparam int RDW = 32'h0002_22FA;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1, start = 1'b0, din_vld = 1'b0, out_rdy = 1'b1;
   logic [7:0] din = 8'h00;
   logic [TW-1:0] tmo = 8'd6;
   logic cfg_cs, cfg_we, cfg_rd_en, out_vld, done, stall;
   logic [7:0] cfg_dout, out_data;
   logic [FRM_W-1:0] out_frame;
   logic [BYT_W-1:0] out_byte;
   logic [CNT_W-1:0] rx_count;

   cfgrb_seq #(.FRAME_BYTES(FB), .NUM_FRAMES(NF), .PAD_BYTES(PB), .LEAD_FRAMES(LF),
               .TMO_W(TW), .DEV_ID(DEVID), .FRAME_ADDR(32'h0), .RD_WORDS(RDW)) u_cfgrb_seq (
      .clk(clk), .rst(rst), .start(start), .tmo_limit(tmo),
      .cfg_cs(cfg_cs), .cfg_we(cfg_we), .cfg_dout(cfg_dout), .cfg_rd_en(cfg_rd_en),
      .cfg_din(din), .cfg_din_vld(din_vld), .out_vld(out_vld), .out_rdy(out_rdy),
      .out_data(out_data), .out_frame(out_frame), .out_byte(out_byte),
      .done(done), .stall(stall), .rx_count(rx_count));

   int n_chk = 0, n_bad = 0, done_seen = 0, hs_seen = 0;
   bit finished = 0;
   logic [31:0] words [11];

   // behavioural reference state
   int m_state = 0, m_cmd = 0, m_sp = 0, m_rx = 0, m_idle = 0, dev_pos = 0;
   int m_odata = 0, m_ofrm = 0, m_obyte = 0;
   bit m_allrx = 0, m_ovld = 0, m_olast = 0, m_done = 0, m_stall = 0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] dev_byte(input int p);
      return 8'((p * 37 + 11) & 255);
   endfunction

   task automatic model_reset();
      m_state = 0; m_cmd = 0; m_sp = 0; m_rx = 0; m_idle = 0;
      m_allrx = 0; m_ovld = 0; m_olast = 0; m_done = 0; m_stall = 0;
   endtask

   task automatic cyc(input bit r, input bit s, input bit v, input bit rd);
      bit rden, acc, fx;
      int slot, pos, exp_dout;
      @(negedge clk);
      rst = r; start = s; din_vld = v; out_rdy = rd; din = dev_byte(dev_pos);
      #1;
      exp_dout = (m_state == 1) ? ((words[m_cmd / 4] >> (24 - 8 * (m_cmd % 4))) & 255) : 0;
      rden = (m_state == 2) && !m_allrx && !(m_ovld && !rd);
      chk("R2", "cfg_cs", cfg_cs, m_state != 0);
      chk("R2", "cfg_we", cfg_we, m_state == 1);
      chk("R2", "cfg_dout", cfg_dout, exp_dout);
      chk("R3", "cfg_rd_en", cfg_rd_en, rden);
      chk("R5", "out_vld", out_vld, m_ovld);
      if (m_ovld) begin
         chk("R5", "out_data", out_data, m_odata);
         chk("R4", "out_frame", out_frame, m_ofrm);
         chk("R4", "out_byte", out_byte, m_obyte);
      end
      chk("R6", "done", done, m_done);
      chk("R7", "stall", stall, m_stall);
      chk("R9", "rx_count", rx_count, m_rx);
      if (done === 1'b1) done_seen++;
      if (out_vld === 1'b1 && rd) hs_seen++;
      if (r) model_reset();
      else begin
         acc = rden && v;
         fx = m_ovld && rd && m_olast;
         m_done = fx;
         if (m_ovld && rd) m_ovld = 0;
         case (m_state)
            0: if (s) begin
                  m_state = 1; m_cmd = 0; m_sp = 0; m_allrx = 0; m_rx = 0;
                  m_idle = 0; m_stall = 0; m_ovld = 0; m_olast = 0; dev_pos = 0;
               end
            1: if (m_cmd == 43) begin m_state = 2; m_cmd = 0; end else m_cmd++;
            default: begin
               if (rden && !v) begin
                  if (m_idle + 1 == int'(tmo)) begin m_stall = 1; m_idle = 0; m_state = 0; end
                  else m_idle++;
               end
               if (acc) begin
                  m_idle = 0;
                  slot = m_sp / SLOT; pos = m_sp % SLOT;
                  if (slot >= LF && pos >= PB) begin
                     m_ovld = 1; m_odata = din; m_ofrm = slot - LF; m_obyte = pos - PB;
                     m_olast = (m_sp == TOTAL - 1); m_rx++;
                  end
                  m_sp++; dev_pos++;
                  if (m_sp == TOTAL) m_allrx = 1;
               end
               if (fx) m_state = 0;
            end
         endcase
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int d0;
      words[0] = 32'hFFFF_FFFF; words[1] = 32'hAA99_5566; words[2] = 32'h3001_C001;
      words[3] = DEVID;         words[4] = 32'h3000_8001; words[5] = 32'h0000_0004;
      words[6] = 32'h3000_2001; words[7] = 32'h0000_0000; words[8] = 32'h2800_6000;
      words[9] = 32'h4800_0000 | RDW; words[10] = 32'h0;

      // R1 reset state
      repeat (3) cyc(1, 0, 0, 1);
      @(posedge clk); #1;
      chk("R1", "cfg_cs", cfg_cs, 0);   chk("R1", "cfg_we", cfg_we, 0);
      chk("R1", "cfg_dout", cfg_dout, 0); chk("R1", "cfg_rd_en", cfg_rd_en, 0);
      chk("R1", "out_vld", out_vld, 0); chk("R1", "done", done, 0);
      chk("R1", "stall", stall, 0);     chk("R1", "rx_count", rx_count, 0);

      // full readback, no gaps, no backpressure
      cyc(0, 1, 1, 1);
      for (int i = 0; i < 150; i++) cyc(0, 0, 1, 1);
      chk("R9", "rx_count after done", rx_count, NF * FB);
      chk("R6", "done pulses", done_seen, 1);
      chk("R4", "payload handshakes", hs_seen, NF * FB);

      // gapped input, backpressure, stray starts (R8)
      d0 = done_seen;
      cyc(0, 1, 1, 1);
      for (int i = 0; i < 300; i++)
         cyc(0, (i == 20) || (i == 70) || (i == 90), (i % 3) != 1, (i % 4) != 2);
      chk("R8", "single done despite starts", done_seen - d0, 1);
      chk("R8", "rx_count", rx_count, NF * FB);

      // stall: 20 bytes taken, then silence
      cyc(0, 1, 0, 1);
      for (int i = 0; i < 75; i++) cyc(0, 0, (i >= 44) && (i < 64), 1);
      chk("R7", "stall flag", stall, 1);
      chk("R7", "cs after stall", cfg_cs, 0);
      chk("R7", "payload count at stall", rx_count, 4);

      // restart clears stall, then reset mid-run
      cyc(0, 1, 1, 1);
      cyc(0, 0, 1, 1);
      chk("R7", "stall cleared by start", stall, 0);
      for (int i = 0; i < 60; i++) cyc(0, 0, 1, 1);
      cyc(1, 0, 1, 1);
      @(posedge clk); #1;
      chk("R10", "cs after reset", cfg_cs, 0);
      chk("R10", "stall after reset", stall, 0);
      chk("R10", "rd_en after reset", cfg_rd_en, 0);
      d0 = done_seen;
      cyc(0, 1, 1, 1);
      for (int i = 0; i < 150; i++) cyc(0, 0, 1, 1);
      chk("R10", "done after recovery", done_seen - d0, 1);
      chk("R10", "rx_count after recovery", rx_count, NF * FB);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule